// File: doc/BRIEF.md
# PCI Configuration Access Address Generator

This block sits between a processor-side request port and a PCI master engine and turns a configuration-space request into one or two configuration cycles. A request carries a bus number, a device/function number, a register offset, an access size, optional write data and a flag that selects the bridge's own configuration header. The block works out whether the request is legal and in range. It then forms the configuration-window address and the one-hot IDSEL line, and records the target bus in a status word. It converts data between the big-endian system side and the little-endian PCI side and reports the result on a response port.

The PCI side is a plain request/acknowledge port: the block raises `pciReq` with an address and, for writes, data, and the target acknowledges once, with `pciAbort` marking a master abort. Sub-word reads take their lane from one aligned 32-bit read. Sub-word writes read the enclosing word, merge the new lane and write the word back. A master abort makes the read word all ones and sets a sticky timeout flag in the status word. Only one request is outstanding at a time.

Top module: `pci_cfg_addr_gen`

## Requirements
- R1: The PCI address is `WIN_BASE | (effDevfn << 8) | (offset & 0xFC)`, where effDevfn is the device/function value plus 48 on bus 0 and the raw device/function value on any other bus.
- R2: During a bus-0 cycle `pciIdsel` has exactly bit (device/function >> 3) set. On other buses and for bridge-header accesses it is zero, and it is zero whenever `pciReq` is low.
- R3: A request with `reqSelf` high uses bus 0 and device/function 0 with no bias, so its address is `WIN_BASE | (offset & 0xFC)`, and the bus inputs are disregarded.
- R4: `statusWord[26:23]` holds the bus number of the most recent request that produced a PCI cycle (0 for the bridge header). It resets to 0 and is left unchanged by requests that are ignored or rejected.
- R5: Data is byte-reversed in both directions: `pciWdata` carries the system word with its four bytes in reverse order, and read data from `pciRdata` is reversed the same way before use.
- R6: A cycle acknowledged with `pciAbort` high reads as 0xFFFFFFFF before lane selection, so byte and half reads return 0xFF and 0xFFFF.
- R7: `statusWord[8]` is set by any aborted cycle. It stays set until a bridge-header write to an offset in 4..7 is accepted, and nothing else clears it.
- R8: A non-bridge request whose bus number is above 15 or whose device number (device/function >> 3) is above 15 runs no PCI cycle and responds with `rspErr` low. A read returns 0xFFFFFFFF for every size, and a write has no effect. This check comes before the alignment check.
- R9: Size codes are 0 byte, 1 half, 2 word, 3 invalid. Size 3, a half at an odd offset, or a word at an offset not a multiple of 4 runs no cycle and responds with `rspErr` high and `rspData` 0.
- R10: A byte or half read returns the lane starting at bit (offset & 3) × 8 of the converted word, zero-extended.
- R11: A byte or half write runs one read and then one write of the same address. Only the addressed lane changes and the other bytes keep their read value. A word write runs a single write cycle.
- R12: `statusWord[13]` follows `hostSlot`. Every status bit other than 26:23, 13 and 8 reads 0.
- R13: `reqReady` is high only when no request is in progress. Once raised, `pciReq` keeps its address stable until it is acknowledged. Each request produces exactly one `rspValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSlot | input | 1 | High when the bridge occupies the host slot |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqSelf | input | 1 | Address the bridge's own configuration header |
| reqWrite | input | 1 | 1 write, 0 read |
| reqBus | input | BUS_W (8) | Target bus number |
| reqDevfn | input | DF_W (8) | Device (bits 7:3) and function (bits 2:0) |
| reqOff | input | OFF_W (8) | Register byte offset |
| reqSize | input | 2 | 0 byte, 1 half, 2 word, 3 invalid |
| reqWdata | input | 32 | Write data, right-aligned for sub-word sizes |
| rspValid | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Request rejected for size or alignment |
| rspData | output | 32 | Read result |
| pciReq | output | 1 | Configuration cycle requested |
| pciWrite | output | 1 | Cycle direction, 1 write |
| pciAddr | output | 32 | Configuration window address |
| pciIdsel | output | 16 | One-hot IDSEL, bit 0 is AD16 |
| pciWdata | output | 32 | Byte-reversed write word |
| pciAck | input | 1 | Target acknowledges the cycle |
| pciAbort | input | 1 | Master abort, valid with pciAck |
| pciRdata | input | 32 | Read word in PCI byte order, valid with pciAck |
| statusWord | output | 32 | Bus field 26:23, host bit 13, timeout bit 8 |

## Verification
Directed cases cover the edges of the address map: device 0 and device 15 on bus 0, a non-zero bus, the bridge header, and bus 16 and device 16 as out-of-range values. Together these separate the bus-0 bias, the IDSEL decode and the bridge-header bypass. A random mix of sizes, offsets, directions and buses follows. Because the target aborts a fixed pattern of addresses, both the all-ones substitution and the sticky flag are exercised among normal transfers. Each sub-word write is compared against the target's stored word, which shows whether the merge, the lane position and the byte reversal are each correct. A count of cycles per request tells a read-modify-write apart from a direct write and from the no-cycle paths.

// File: rtl/pci_cfg_gen_pkg.sv
package pci_cfg_gen_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    K_RUN  = 2'd0,
    K_SKIP = 2'd1,
    K_BAD  = 2'd2
  } kind_e;

  typedef struct packed {
    logic capture;
    logic latchRd;
    logic abortSeen;
  } strobe_t;

  localparam int STAT_BUS_LO  = 23;
  localparam int STAT_HOST    = 13;
  localparam int STAT_TIMEOUT = 8;

  function automatic logic [31:0] swapBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/pci_cfg_ctrl.sv
module pci_cfg_ctrl
  import pci_cfg_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  kind_e   decKind,
  input  logic    decWordWrite,
  input  logic    heldWrite,
  input  logic    pciAck,
  input  logic    pciAbort,
  output strobe_t strb,
  output logic    reqReady,
  output logic    rspValid,
  output logic    pciReq,
  output logic    pciWrite
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_RESP} state_e;
  state_e state, nextState;

  always_comb begin
    nextState      = state;
    strb           = '0;
    strb.abortSeen = pciReq && pciAck && pciAbort;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strb.capture = 1'b1;
        if (decKind != K_RUN)  nextState = S_RESP;
        else if (decWordWrite) nextState = S_WR;
        else                   nextState = S_RD;
      end
      S_RD: if (pciAck) begin
        strb.latchRd = 1'b1;
        nextState    = heldWrite ? S_WR : S_RESP;
      end
      S_WR:   if (pciAck) nextState = S_RESP;
      S_RESP: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);
  assign pciReq   = (state == S_RD) || (state == S_WR);
  assign pciWrite = (state == S_WR);

endmodule

// File: rtl/pci_cfg_datapath.sv
module pci_cfg_datapath
  import pci_cfg_gen_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'hC001_0000,
  parameter int          BUS_W      = 8,
  parameter int          DF_W       = 8,
  parameter int          OFF_W      = 8,
  parameter int          FIELD_W    = 4,
  parameter int          DEVFN_BIAS = 48
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                hostSlot,
  input  logic                reqSelf,
  input  logic                reqWrite,
  input  logic [BUS_W-1:0]    reqBus,
  input  logic [DF_W-1:0]     reqDevfn,
  input  logic [OFF_W-1:0]    reqOff,
  input  logic [1:0]          reqSize,
  input  logic [31:0]         reqWdata,
  input  logic                pciAbort,
  input  logic [31:0]         pciRdata,
  output kind_e               decKind,
  output logic                decWordWrite,
  output logic                heldWrite,
  output logic                rspErr,
  output logic [31:0]         rspData,
  output logic [31:0]         pciAddr,
  output logic [(1<<FIELD_W)-1:0] idselReg,
  output logic [31:0]         pciWdata,
  output logic [31:0]         statusWord
);

  localparam int NUM_DEV  = 1 << FIELD_W;
  localparam int MAX_IDX  = NUM_DEV - 1;
  localparam int DEV_W    = DF_W - 3;

  // request decode
  logic [DEV_W-1:0] devNum;
  logic             outOfRange, misaligned;
  logic [DF_W-1:0]  effDevfn;
  logic [NUM_DEV-1:0] idselNext;
  logic             clearsTimeout;

  assign devNum     = reqDevfn[DF_W-1:3];
  assign outOfRange = !reqSelf && ((reqBus > BUS_W'(MAX_IDX)) || (devNum > DEV_W'(MAX_IDX)));
  assign misaligned = (size_e'(reqSize) == SZ_BAD) ||
                      ((size_e'(reqSize) == SZ_HALF) && reqOff[0]) ||
                      ((size_e'(reqSize) == SZ_WORD) && (reqOff[1:0] != 2'b00));

  always_comb begin
    if (outOfRange)      decKind = K_SKIP;
    else if (misaligned) decKind = K_BAD;
    else                 decKind = K_RUN;
  end

  assign decWordWrite = reqWrite && (size_e'(reqSize) == SZ_WORD);

  always_comb begin
    if (reqSelf)            effDevfn = '0;
    else if (reqBus == '0)  effDevfn = reqDevfn + DF_W'(DEVFN_BIAS);
    else                    effDevfn = reqDevfn;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_idsel
    assign idselNext[d] = !reqSelf && (reqBus == '0) && (devNum == DEV_W'(d));
  end

  assign clearsTimeout = reqSelf && reqWrite && (reqOff[OFF_W-1:2] == (OFF_W-2)'(1));

  // held request state
  kind_e            hKind;
  logic [1:0]       hSize;
  logic [1:0]       hLane;
  logic [31:0]      hWdata;
  logic [31:0]      rdWord;
  logic [FIELD_W-1:0] busField;
  logic             timeoutFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hKind       <= K_RUN;
      heldWrite   <= 1'b0;
      hSize       <= 2'd0;
      hLane       <= 2'd0;
      hWdata      <= '0;
      rdWord      <= '0;
      pciAddr     <= '0;
      idselReg    <= '0;
      busField    <= '0;
      timeoutFlag <= 1'b0;
    end else begin
      if (strb.capture) begin
        hKind     <= decKind;
        heldWrite <= reqWrite;
        hSize     <= reqSize;
        hLane     <= reqOff[1:0];
        hWdata    <= reqWdata;
        if (decKind == K_RUN) begin
          pciAddr  <= WIN_BASE | {16'b0, effDevfn, 8'b0} |
                      {24'b0, reqOff[7:2], 2'b00};
          idselReg <= idselNext;
          busField <= reqSelf ? '0 : reqBus[FIELD_W-1:0];
          if (clearsTimeout) timeoutFlag <= 1'b0;
        end
      end
      if (strb.latchRd)
        rdWord <= pciAbort ? 32'hFFFF_FFFF : swapBytes(pciRdata);
      if (strb.abortSeen)
        timeoutFlag <= 1'b1;
    end
  end

  // lane handling
  logic [4:0]  shiftAmt;
  logic [31:0] laneMask, shifted, merged;

  assign shiftAmt = {hLane, 3'b000};
  assign laneMask = (size_e'(hSize) == SZ_BYTE) ? 32'h0000_00FF : 32'h0000_FFFF;
  assign shifted  = rdWord >> shiftAmt;

  always_comb begin
    if (size_e'(hSize) == SZ_WORD) merged = hWdata;
    else merged = (rdWord & ~(laneMask << shiftAmt)) | ((hWdata & laneMask) << shiftAmt);
  end

  assign pciWdata = swapBytes(merged);

  always_comb begin
    rspErr  = (hKind == K_BAD);
    rspData = '0;
    unique case (hKind)
      K_SKIP: rspData = heldWrite ? 32'h0 : 32'hFFFF_FFFF;
      K_RUN: if (!heldWrite) begin
        if (size_e'(hSize) == SZ_WORD) rspData = rdWord;
        else                           rspData = shifted & laneMask;
      end
      default: rspData = '0;
    endcase
  end

  always_comb begin
    statusWord = '0;
    statusWord[STAT_BUS_LO +: FIELD_W] = busField;
    statusWord[STAT_HOST]              = hostSlot;
    statusWord[STAT_TIMEOUT]           = timeoutFlag;
  end

endmodule

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen
  import pci_cfg_gen_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'hC001_0000,
  parameter int          BUS_W      = 8,
  parameter int          DF_W       = 8,
  parameter int          OFF_W      = 8,
  parameter int          FIELD_W    = 4,
  parameter int          DEVFN_BIAS = 48
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostSlot,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqSelf,
  input  logic                    reqWrite,
  input  logic [BUS_W-1:0]        reqBus,
  input  logic [DF_W-1:0]         reqDevfn,
  input  logic [OFF_W-1:0]        reqOff,
  input  logic [1:0]              reqSize,
  input  logic [31:0]             reqWdata,
  output logic                    rspValid,
  output logic                    rspErr,
  output logic [31:0]             rspData,
  output logic                    pciReq,
  output logic                    pciWrite,
  output logic [31:0]             pciAddr,
  output logic [(1<<FIELD_W)-1:0] pciIdsel,
  output logic [31:0]             pciWdata,
  input  logic                    pciAck,
  input  logic                    pciAbort,
  input  logic [31:0]             pciRdata,
  output logic [31:0]             statusWord
);

  strobe_t strb;
  kind_e   decKind;
  logic    decWordWrite, heldWrite;
  logic [(1<<FIELD_W)-1:0] idselReg;

  pci_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .decKind(decKind),
    .decWordWrite(decWordWrite), .heldWrite(heldWrite), .pciAck(pciAck),
    .pciAbort(pciAbort), .strb(strb), .reqReady(reqReady),
    .rspValid(rspValid), .pciReq(pciReq), .pciWrite(pciWrite)
  );

  pci_cfg_datapath #(
    .WIN_BASE(WIN_BASE), .BUS_W(BUS_W), .DF_W(DF_W), .OFF_W(OFF_W),
    .FIELD_W(FIELD_W), .DEVFN_BIAS(DEVFN_BIAS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostSlot(hostSlot),
    .reqSelf(reqSelf), .reqWrite(reqWrite), .reqBus(reqBus),
    .reqDevfn(reqDevfn), .reqOff(reqOff), .reqSize(reqSize),
    .reqWdata(reqWdata), .pciAbort(pciAbort), .pciRdata(pciRdata),
    .decKind(decKind), .decWordWrite(decWordWrite), .heldWrite(heldWrite),
    .rspErr(rspErr), .rspData(rspData), .pciAddr(pciAddr),
    .idselReg(idselReg), .pciWdata(pciWdata), .statusWord(statusWord)
  );

  assign pciIdsel = pciReq ? idselReg : '0;

endmodule

// File: rtl/pci_cfg_addr_gen_chk.sv
module pci_cfg_addr_gen_chk #(
  parameter int BUS_W   = 8,
  parameter int OFF_W   = 8,
  parameter int FIELD_W = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    hostSlot,
  input logic                    reqValid,
  input logic                    reqReady,
  input logic                    reqSelf,
  input logic                    reqWrite,
  input logic [BUS_W-1:0]        reqBus,
  input logic [OFF_W-1:0]        reqOff,
  input logic                    rspValid,
  input logic                    pciReq,
  input logic                    pciAck,
  input logic                    pciAbort,
  input logic [31:0]             pciAddr,
  input logic [(1<<FIELD_W)-1:0] pciIdsel,
  input logic [31:0]             statusWord
);

  logic clearReq;
  assign clearReq = reqValid && reqReady && reqSelf && reqWrite &&
                    (reqOff[OFF_W-1:2] == (OFF_W-2)'(1));

  a_r13_req_held: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && !pciAck |=> pciReq && $stable(pciAddr));

  a_r13_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (pciReq || rspValid) |-> !reqReady);

  a_r2_idsel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pciIdsel) && (!pciReq -> (pciIdsel == '0)));

  a_r7_abort_sets: assert property (@(posedge clk) disable iff (!rstN)
    pciReq && pciAck && pciAbort |=> statusWord[8]);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[8] && !clearReq |=> statusWord[8]);

  a_r12_host_bit: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[13] == hostSlot);

  a_r8_far_bus_no_cycle: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !reqSelf && (reqBus > BUS_W'((1<<FIELD_W)-1)) |=> !pciReq);

endmodule

bind pci_cfg_addr_gen pci_cfg_addr_gen_chk #(
  .BUS_W(BUS_W), .OFF_W(OFF_W), .FIELD_W(FIELD_W)
) u_chk (.*);

// File: tb/pci_cfg_addr_gen_tb.sv
module pci_cfg_addr_gen_tb;

  localparam logic [31:0] BASE = 32'hC001_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSlot = 1'b1;
  logic        reqValid = 1'b0, reqReady, reqSelf = 1'b0, reqWrite = 1'b0;
  logic [7:0]  reqBus = '0, reqDevfn = '0, reqOff = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid, rspErr;
  logic [31:0] rspData;
  logic        pciReq, pciWrite;
  logic [31:0] pciAddr, pciWdata, statusWord;
  logic [15:0] pciIdsel;
  logic        pciAck = 1'b0, pciAbort = 1'b0;
  logic [31:0] pciRdata = '0;

  int checks = 0, fails = 0;
  int ackCount = 0;
  logic [31:0] lastAddr;
  logic [15:0] lastIdsel;
  int dly = 0;
  logic [31:0] mem [logic [35:0]];

  always #2.5 clk = ~clk;

  pci_cfg_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .hostSlot(hostSlot), .reqValid(reqValid),
    .reqReady(reqReady), .reqSelf(reqSelf), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDevfn(reqDevfn), .reqOff(reqOff),
    .reqSize(reqSize), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspErr(rspErr), .rspData(rspData), .pciReq(pciReq),
    .pciWrite(pciWrite), .pciAddr(pciAddr), .pciIdsel(pciIdsel),
    .pciWdata(pciWdata), .pciAck(pciAck), .pciAbort(pciAbort),
    .pciRdata(pciRdata), .statusWord(statusWord)
  );

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] dflt(input logic [35:0] k);
    return (k[31:0] * 32'h9E37_79B9) ^ {k[35:32], 28'h0};
  endfunction

  function automatic logic [31:0] memRd(input logic [35:0] k);
    if (mem.exists(k)) return mem[k];
    return dflt(k);
  endfunction

  function automatic logic abortRule(input logic [31:0] a);
    return a[13:11] == 3'b101;
  endfunction

  // bench target
  always @(posedge clk) begin
    if (pciReq && pciAck) begin
      ackCount  = ackCount + 1;
      lastAddr  = pciAddr;
      lastIdsel = pciIdsel;
      if (pciWrite && !pciAbort) mem[{statusWord[26:23], pciAddr}] = pciWdata;
    end
    pciAck <= 1'b0;
    if (pciReq && !pciAck) begin
      if (dly == 0) begin
        pciAck   <= 1'b1;
        pciAbort <= abortRule(pciAddr);
        pciRdata <= memRd({statusWord[26:23], pciAddr});
        dly      = int'($urandom % 3);
      end else dly = dly - 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic       expTo = 1'b0;
  logic [3:0] expBus = '0;

  task automatic access(input logic self, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [7:0] off, input logic [1:0] size,
                        input logic wr, input logic [31:0] wdata);
    logic oob, bad, run, ab;
    logic [7:0]  eDf;
    logic [31:0] eAddr, pre, word, merged, mask, eData;
    logic [15:0] eIdsel;
    logic [35:0] key;
    logic [4:0]  sh;
    int eCyc, guard;
    logic gotErr;
    logic [31:0] gotData;
    oob = !self && (bus > 15 || devfn[7]);
    bad = (size == 2'd3) || (size == 2'd1 && off[0]) || (size == 2'd2 && off[1:0] != 2'b00);
    run = !oob && !bad;
    eDf = self ? 8'd0 : (bus == 0 ? devfn + 8'd48 : devfn);
    eAddr = BASE | {16'b0, eDf, 8'b0} | {24'b0, off[7:2], 2'b00};
    eIdsel = (!self && bus == 0) ? (16'h1 << devfn[6:3]) : 16'h0;
    key = {self ? 4'd0 : bus[3:0], eAddr};
    ab = abortRule(eAddr);
    pre = ab ? 32'hFFFF_FFFF : bsw(memRd(key));
    sh = {off[1:0], 3'b000};
    mask = (size == 2'd0) ? 32'hFF : 32'hFFFF;
    merged = (size == 2'd2) ? wdata : ((pre & ~(mask << sh)) | ((wdata & mask) << sh));
    word = memRd(key);
    if (bad && !oob) eData = 32'h0;
    else if (oob) eData = wr ? 32'h0 : 32'hFFFF_FFFF;
    else if (wr) eData = 32'h0;
    else eData = (size == 2'd2) ? pre : ((pre >> sh) & mask);
    eCyc = !run ? 0 : (wr && size != 2'd2) ? 2 : 1;

    @(negedge clk);
    reqSelf = self; reqBus = bus; reqDevfn = devfn; reqOff = off;
    reqSize = size; reqWrite = wr; reqWdata = wdata; reqValid = 1'b1;
    ackCount = 0;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R13 busy", 36'(reqReady), 36'h0);
    guard = 0;
    while (!rspValid && guard < 100) begin @(negedge clk); guard++; end
    gotErr = rspErr; gotData = rspData;
    chk(guard < 100, "R13 response", 36'(guard), 36'h0);
    @(negedge clk);
    chk(!rspValid, "R13 single pulse", 36'(rspValid), 36'h0);

    if (run) begin
      expBus = self ? 4'd0 : bus[3:0];
      if (self && wr && off[7:2] == 6'd1) expTo = 1'b0;
      if (ab) expTo = 1'b1;
    end
    chk(gotErr == (bad && !oob), "R9 err", 36'(gotErr), 36'(bad && !oob));
    chk(gotData == eData, oob ? "R8 data" : (size != 2'd2 && !wr) ? "R10 lane" : "R6 data",
        36'(gotData), 36'(eData));
    chk(ackCount == eCyc, (eCyc == 2) ? "R11 cycles" : "R9 cycles", 36'(ackCount), 36'(eCyc));
    if (run) begin
      chk(lastAddr == eAddr, self ? "R3 addr" : "R1 addr", 36'(lastAddr), 36'(eAddr));
      chk(lastIdsel == eIdsel, "R2 idsel", 36'(lastIdsel), 36'(eIdsel));
      if (wr) begin
        if (ab) chk(memRd(key) == word, "R11 untouched", memRd(key), word);
        else    chk(memRd(key) == bsw(merged), "R5 written", memRd(key), bsw(merged));
      end
    end
    chk(statusWord[26:23] == expBus, "R4 bus", 36'(statusWord[26:23]), 36'(expBus));
    chk(statusWord[8] == expTo, "R7 timeout", 36'(statusWord[8]), 36'(expTo));
    chk((statusWord & ~32'h0780_2100) == 0, "R12 zero bits", statusWord, 36'h0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(reqReady && !pciReq && !rspValid, "R13 reset", 36'({reqReady, pciReq, rspValid}), 36'h4);
    chk(statusWord == 32'h0000_2000, "R4 R12 reset", statusWord, 36'h2000);
    rstN = 1'b1;
    @(negedge clk);
    hostSlot = 1'b0;
    @(negedge clk);
    chk(statusWord[13] == 1'b0, "R12 host", 36'(statusWord[13]), 36'h0);
    hostSlot = 1'b1;

    // directed corners
    access(1'b0, 8'd0, 8'h00, 8'h00, 2'd2, 1'b0, 0);           // R1 device 0 -> AD16
    access(1'b0, 8'd0, 8'h7F, 8'h3C, 2'd2, 1'b0, 0);           // R6 device 15 aborts
    access(1'b0, 8'd3, 8'h21, 8'h10, 2'd2, 1'b0, 0);           // R7 stays set
    access(1'b1, 8'd9, 8'h55, 8'h00, 2'd2, 1'b0, 0);           // R3 bridge header
    access(1'b1, 8'd0, 8'h00, 8'h06, 2'd1, 1'b1, 32'h0000_BEEF); // R7 clear, R11 half
    access(1'b0, 8'd16, 8'h08, 8'h00, 2'd2, 1'b0, 0);          // R8 bus 16
    access(1'b0, 8'd1, 8'h80, 8'h00, 2'd3, 1'b1, 32'h1);       // R8 before R9
    access(1'b0, 8'd0, 8'h08, 8'h01, 2'd1, 1'b0, 0);           // R9 odd half
    access(1'b0, 8'd0, 8'h08, 8'h02, 2'd2, 1'b0, 0);           // R9 unaligned word
    access(1'b0, 8'd0, 8'h08, 8'h00, 2'd3, 1'b0, 0);           // R9 size 3
    access(1'b0, 8'd2, 8'h0A, 8'h13, 2'd0, 1'b1, 32'h0000_00A7); // R11 byte lane 3
    access(1'b0, 8'd2, 8'h0A, 8'h13, 2'd0, 1'b0, 0);           // R10 byte readback
    access(1'b0, 8'd0, 8'h11, 8'h20, 2'd2, 1'b1, 32'h1234_5678); // R5 word write
    access(1'b0, 8'd0, 8'h11, 8'h20, 2'd2, 1'b0, 0);           // R5 readback

    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      b = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 4);
      access(($urandom % 8) == 0, b, 8'($urandom), 8'($urandom % 64),
             2'($urandom), 1'($urandom), $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule